// File: doc/BRIEF.md
# Automatic RS-485 Direction Control from Bit Timing

This block sits between a host UART and a half-duplex RS-485 transceiver. The transmit line passes through it with one register stage of delay. The block drives the transceiver's driver-enable output so that it is high for exactly as long as characters are on the wire. When the line goes quiet, the enable drops and the bus returns to receive. The receive line passes back to the host without change.

The block does not read the UART's internal state. Instead it times each character. A falling edge on the idle-high transmit line starts a symbol. The symbol lasts a programmed number of bit periods, each a programmed number of clock cycles. Software loads these two values once, after the line rate and the frame format are chosen. A format with 8 data bits, no parity and one stop bit counts as 10 bits per symbol. Parity or 9-bit formats are programmed as 11 or 12. With the default 16-bit divider and a 125 MHz clock, the bit period can be set anywhere from 1 cycle up to 65535 cycles. That covers line rates of 5 Mb/s (25 cycles per bit) and slower.

Top module: `rs485_txen_gen`

## Requirements
- R1: Under reset, `xcvr_txen` is 0 and `xcvr_tx` is 1. After reset and before any load, the timing is 1085 cycles per bit and 10 bits per symbol.
- R2: `xcvr_tx` equals `host_tx` delayed by exactly one clock cycle.
- R3: `host_rx` equals `line_rx` in the same cycle.
- R4: While no symbol is in progress, a high-to-low change on `xcvr_tx` raises `xcvr_txen` in the same cycle that the low level first appears on `xcvr_tx`.
- R5: A single symbol holds `xcvr_txen` high for exactly bit-period × bits-per-symbol cycles, counted from the cycle in R4.
- R6: If `xcvr_tx` is low in the first cycle after a symbol's last cycle, a new symbol starts in that cycle. `xcvr_txen` stays high with no gap, so a burst of N back-to-back symbols gives one unbroken enable of N symbol lengths.
- R7: If `xcvr_tx` is high in the first cycle after a symbol's last cycle, `xcvr_txen` is low in that cycle.
- R8: A one-cycle pulse on `cfg_load` captures `cfg_div` (clock cycles per bit) and `cfg_bits` (bits per symbol) into pending settings. A value of 0 in either field is stored as 1.
- R9: Pending settings become active only while no symbol is in progress and the cycle after the last symbol has passed. A load made during a burst does not change any symbol of that burst, including back-to-back symbols that follow it. The first symbol started from idle uses the new values.
- R10: Level changes on the transmit line inside a symbol (data and parity bits) neither shorten nor extend the enable window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load pulse for the timing settings |
| cfg_div | input | DIV_W | Clock cycles per bit period |
| cfg_bits | input | BITS_W | Bits per symbol, including start and stop |
| host_tx | input | 1 | Transmit data from the host UART |
| xcvr_tx | output | 1 | Transmit data to the transceiver, delayed one cycle |
| xcvr_txen | output | 1 | Transceiver driver enable |
| line_rx | input | 1 | Receive data from the transceiver |
| host_rx | output | 1 | Receive data to the host UART |

## Verification
The hardest situations to reach are the cycle right after a symbol's last cycle and a new setting arriving in the middle of a burst. To reach the first, the bench sends characters whose stop bit lasts exactly one bit period, with the next start bit directly behind it. This lands a low level precisely on that cycle. Separately, a single-cycle bit period with one bit per symbol makes every cycle such a boundary. For the second, a load pulse is forked in parallel with a two-character burst. The reference model then shows whether the second character kept the old timing and the next burst took the new one.

// File: rtl/rs485_txen_pkg.sv
`timescale 1ns/1ps
// Shared types for the automatic RS-485 driver-enable generator.
// Assumes nothing beyond a single clock domain.
package rs485_txen_pkg;

    // Sequencer phase: idle line, inside a symbol, or the single cycle
    // directly after a symbol where a back-to-back start may follow.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SYMBOL = 2'd1,
        PH_SEAM   = 2'd2
    } phase_e;

endpackage

// File: rtl/txen_line_tap.sv
`timescale 1ns/1ps
// Line tap: registers the host transmit line once, flags a falling
// edge on the registered copy, and forwards receive data unchanged.
// Assumes host_tx is synchronous to clk; idle level is high.
module txen_line_tap (
    input  logic clk,
    input  logic rst_n,
    input  logic host_tx,
    input  logic line_rx,
    output logic tx_dly,
    output logic tx_fall,
    output logic host_rx
);

    logic tx_prev;

    // Delay stage for transmit data and the copy used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_dly  <= 1'b1;
            tx_prev <= 1'b1;
        end else begin
            tx_dly  <= host_tx;
            tx_prev <= tx_dly;
        end
    end

    // High-to-low change visible on the delayed line this cycle.
    always_comb tx_fall = tx_prev & ~tx_dly;

    // Receive path is a plain wire.
    always_comb host_rx = line_rx;

    assert_tx_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (tx_dly == $past(host_tx)));

endmodule

// File: rtl/txen_cfg_regs.sv
`timescale 1ns/1ps
// Timing settings: a pending copy written by cfg_load and an active copy
// that follows the pending copy only while hold is low (line idle).
// The effective value is the pending copy when idle, else the active copy.
// Assumes cfg_load is a single-cycle strobe; zero is stored as one.
module txen_cfg_regs #(
    parameter int unsigned DIV_W    = 16,
    parameter int unsigned BITS_W   = 4,
    parameter int unsigned DEF_DIV  = 1085,
    parameter int unsigned DEF_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [BITS_W-1:0] cfg_bits,
    input  logic              hold,
    output logic [DIV_W-1:0]  eff_div,
    output logic [BITS_W-1:0] eff_bits
);

    localparam logic [DIV_W-1:0]  RST_DIV  = DIV_W'(DEF_DIV);
    localparam logic [BITS_W-1:0] RST_BITS = BITS_W'(DEF_BITS);
    localparam logic [DIV_W-1:0]  ONE_DIV  = DIV_W'(1);
    localparam logic [BITS_W-1:0] ONE_BITS = BITS_W'(1);

    logic [DIV_W-1:0]  pend_div, act_div;
    logic [BITS_W-1:0] pend_bits, act_bits;

    // Pending settings: capture on strobe, replacing zero by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_div  <= RST_DIV;
            pend_bits <= RST_BITS;
        end else if (cfg_load) begin
            pend_div  <= (cfg_div  == '0) ? ONE_DIV  : cfg_div;
            pend_bits <= (cfg_bits == '0) ? ONE_BITS : cfg_bits;
        end
    end

    // Active settings: track the pending copy only when the line is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_div  <= RST_DIV;
            act_bits <= RST_BITS;
        end else if (!hold) begin
            act_div  <= pend_div;
            act_bits <= pend_bits;
        end
    end

    // Settings seen by the sequencer this cycle.
    always_comb begin
        eff_div  = hold ? act_div  : pend_div;
        eff_bits = hold ? act_bits : pend_bits;
    end

    assert_pend_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_div != '0) && (pend_bits != '0));

    assert_act_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (act_div == $past(act_div)) && (act_bits == $past(act_bits)));

endmodule

// File: rtl/txen_symbol_timer.sv
`timescale 1ns/1ps
// Symbol timer: counts clock cycles within a bit and bits within a symbol,
// starting on a falling edge seen while idle, or on a low level in the
// cycle right after a symbol (back-to-back). Drives the driver enable.
// Assumes eff_div and eff_bits are never zero.
module txen_symbol_timer
    import rs485_txen_pkg::*;
#(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned BITS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_low,
    input  logic              tx_fall,
    input  logic [DIV_W-1:0]  eff_div,
    input  logic [BITS_W-1:0] eff_bits,
    output logic              in_burst,
    output logic              txen
);

    localparam logic [DIV_W-1:0]  ONE_DIV  = DIV_W'(1);
    localparam logic [BITS_W-1:0] ONE_BITS = BITS_W'(1);

    phase_e            phase_q, phase_d;
    logic [DIV_W-1:0]  cyc_q, base_cyc, nxt_cyc;
    logic [BITS_W-1:0] bit_q, base_bit, nxt_bit;
    logic              last_cyc, last_bit, sym_done, start;

    // Start condition: fresh edge from idle, or low level at the seam.
    always_comb begin
        start = ((phase_q == PH_IDLE) && tx_fall) ||
                ((phase_q == PH_SEAM) && tx_low);
    end

    // Advance the position by one cycle; a start counts as position zero.
    always_comb begin
        base_cyc = (phase_q == PH_SYMBOL) ? cyc_q : '0;
        base_bit = (phase_q == PH_SYMBOL) ? bit_q : '0;
        last_cyc = (base_cyc == (eff_div  - ONE_DIV));
        last_bit = (base_bit == (eff_bits - ONE_BITS));
        sym_done = last_cyc && last_bit;
        nxt_cyc  = last_cyc ? '0 : (base_cyc + ONE_DIV);
        nxt_bit  = last_cyc ? (base_bit + ONE_BITS) : base_bit;
    end

    // Next phase selection.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (start) phase_d = sym_done ? PH_SEAM : PH_SYMBOL;
            PH_SYMBOL: if (sym_done) phase_d = PH_SEAM;
            PH_SEAM:   phase_d = start ? (sym_done ? PH_SEAM : PH_SYMBOL) : PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase and position registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cyc_q   <= '0;
            bit_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if (start || (phase_q == PH_SYMBOL)) begin
                cyc_q <= nxt_cyc;
                bit_q <= nxt_bit;
            end
        end
    end

    // Enable covers every cycle of a symbol, including the starting one.
    always_comb begin
        txen     = (phase_q == PH_SYMBOL) || start;
        in_burst = (phase_q != PH_IDLE);
    end

    assert_txen_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_IDLE) && tx_fall) |-> txen);

    assert_position_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SYMBOL) |-> ((cyc_q < eff_div) && (bit_q < eff_bits)));

    assert_seam_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_SEAM) && tx_low) |-> txen);

    assert_seam_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_SEAM) && !tx_low) |-> !txen);

endmodule

// File: rtl/rs485_txen_gen.sv
`timescale 1ns/1ps
// Top: automatic RS-485 driver enable derived from programmed bit period
// and symbol length. Transmit data is delayed one cycle and the enable is
// aligned to that delayed copy. Receive data passes straight through.
// Assumes all inputs are synchronous to clk.
module rs485_txen_gen #(
    parameter int unsigned DIV_W    = 16,
    parameter int unsigned BITS_W   = 4,
    parameter int unsigned DEF_DIV  = 1085,
    parameter int unsigned DEF_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [BITS_W-1:0] cfg_bits,
    input  logic              host_tx,
    output logic              xcvr_tx,
    output logic              xcvr_txen,
    input  logic              line_rx,
    output logic              host_rx
);

    logic              tx_fall, in_burst;
    logic [DIV_W-1:0]  eff_div;
    logic [BITS_W-1:0] eff_bits;

    txen_line_tap u_tap (
        .clk     (clk),
        .rst_n   (rst_n),
        .host_tx (host_tx),
        .line_rx (line_rx),
        .tx_dly  (xcvr_tx),
        .tx_fall (tx_fall),
        .host_rx (host_rx)
    );

    txen_cfg_regs #(
        .DIV_W    (DIV_W),
        .BITS_W   (BITS_W),
        .DEF_DIV  (DEF_DIV),
        .DEF_BITS (DEF_BITS)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_div  (cfg_div),
        .cfg_bits (cfg_bits),
        .hold     (in_burst),
        .eff_div  (eff_div),
        .eff_bits (eff_bits)
    );

    txen_symbol_timer #(
        .DIV_W  (DIV_W),
        .BITS_W (BITS_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_low   (~xcvr_tx),
        .tx_fall  (tx_fall),
        .eff_div  (eff_div),
        .eff_bits (eff_bits),
        .in_burst (in_burst),
        .txen     (xcvr_txen)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!xcvr_txen && xcvr_tx));

endmodule

// File: tb/tb_rs485_txen_gen.sv
`timescale 1ns/1ps
module tb_rs485_txen_gen;

    localparam int DEF_DIV = 1085;
    localparam int DEF_BITS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [15:0] cfg_div = '0;
    logic [3:0]  cfg_bits = '0;
    logic        host_tx = 1'b1;
    logic        line_rx = 1'b1;
    logic        xcvr_tx, xcvr_txen, host_rx;

    int n_chk = 0, n_fail = 0;
    bit armed = 0;

    always #4 clk = ~clk;

    rs485_txen_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_div(cfg_div),
        .cfg_bits(cfg_bits), .host_tx(host_tx), .xcvr_tx(xcvr_tx),
        .xcvr_txen(xcvr_txen), .line_rx(line_rx), .host_rx(host_rx)
    );

    // Behavioural reference: total-cycle countdown per symbol.
    int m_pd, m_pb, m_ad, m_ab, m_rem;
    bit m_end, m_txq, m_txd;

    function automatic bit m_start();
        if (m_rem > 0) return 0;
        if (m_end) return !m_txq;
        return m_txd && !m_txq;
    endfunction

    function automatic bit m_txen();
        return (m_rem > 0) || m_start();
    endfunction

    always @(posedge clk) begin
        int d, n;
        bit st, burst;
        if (!rst_n) begin
            m_pd = DEF_DIV; m_pb = DEF_BITS; m_ad = DEF_DIV; m_ab = DEF_BITS;
            m_rem = 0; m_end = 0; m_txq = 1; m_txd = 1;
        end else begin
            st = m_start();
            burst = (m_rem > 0) || m_end;
            d = burst ? m_ad : m_pd;
            n = burst ? m_ab : m_pb;
            if (!burst) begin m_ad = m_pd; m_ab = m_pb; end
            if (st) begin m_rem = d * n - 1; m_end = (d * n == 1); end
            else if (m_rem > 0) begin m_end = (m_rem == 1); m_rem = m_rem - 1; end
            else m_end = 0;
            if (cfg_load) begin
                m_pd = (cfg_div == 0) ? 1 : int'(cfg_div);
                m_pb = (cfg_bits == 0) ? 1 : int'(cfg_bits);
            end
            m_txd = m_txq;
            m_txq = host_tx;
        end
    end

    task automatic check_bit(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison plus enable statistics, sampled mid-cycle.
    int hi_cnt = 0, fall_cnt = 0;
    logic prev_en = 1'b0;
    always @(negedge clk) begin
        if (armed) begin
            check_bit("R4 R5 R6 R7 R9 R10 enable", xcvr_txen, m_txen());
            check_bit("R2 tx delay", xcvr_tx, m_txq);
            check_bit("R3 rx pass", host_rx, line_rx);
            if (xcvr_txen) hi_cnt++;
            if (prev_en && !xcvr_txen) fall_cnt++;
            prev_en = xcvr_txen;
        end
    end

    task automatic tick(int k);
        repeat (k) begin
            @(posedge clk);
            #2;
            line_rx = 1'($urandom);
        end
    endtask

    task automatic clr_stats();
        hi_cnt = 0;
        fall_cnt = 0;
    endtask

    task automatic load_cfg(int d, int n);
        cfg_div = 16'(d);
        cfg_bits = 4'(n);
        cfg_load = 1'b1;
        tick(1);
        cfg_load = 1'b0;
    endtask

    // One symbol: start bit, data bits LSB first, then high stop bit(s).
    task automatic send_sym(logic [15:0] data, int n, int d);
        logic [15:0] pat;
        pat = 16'hFFFF;
        pat[0] = 1'b0;
        for (int i = 1; i < n - 1; i++) pat[i] = data[i-1];
        for (int i = 0; i < n; i++) begin
            host_tx = pat[i];
            tick(d);
        end
        host_tx = 1'b1;
    endtask

    initial begin
        host_tx = 1'b1;
        @(posedge clk);
        armed = 1;
        tick(4);
        // R1: reset state
        @(negedge clk);
        check_bit("R1 txen in reset", xcvr_txen, 1'b0);
        check_bit("R1 tx in reset", xcvr_tx, 1'b1);
        #2;
        rst_n = 1'b1;
        tick(5);

        // R1: default timing, one 10-bit character at 1085 cycles per bit
        clr_stats();
        send_sym(16'h5A, DEF_BITS, DEF_DIV);
        tick(20);
        check_int("R1 default window", hi_cnt, DEF_DIV * DEF_BITS);

        // R5: single character, 4 cycles per bit
        load_cfg(4, 10);
        tick(3);
        clr_stats();
        send_sym(16'h00, 10, 4);
        tick(10);
        check_int("R5 single window", hi_cnt, 40);
        check_int("R7 single release", fall_cnt, 1);

        // R6: three back-to-back characters, 3 cycles per bit
        load_cfg(3, 10);
        tick(3);
        clr_stats();
        send_sym(16'hFF, 10, 3);
        send_sym(16'h81, 10, 3);
        send_sym(16'h3C, 10, 3);
        tick(10);
        check_int("R6 burst window", hi_cnt, 90);
        check_int("R6 no gap", fall_cnt, 1);

        // R9: load during a two-character burst
        clr_stats();
        fork
            begin
                send_sym(16'h55, 10, 3);
                send_sym(16'hAA, 10, 3);
            end
            begin
                tick(5);
                load_cfg(7, 12);
            end
        join
        tick(10);
        check_int("R9 burst keeps old timing", hi_cnt, 60);
        check_int("R9 burst one window", fall_cnt, 1);
        clr_stats();
        send_sym(16'h2A5, 12, 7);
        tick(10);
        check_int("R9 new timing after idle", hi_cnt, 84);

        // R10: parity-length symbol with alternating inner bits
        load_cfg(2, 11);
        tick(3);
        clr_stats();
        send_sym(16'h155, 11, 2);
        tick(6);
        check_int("R10 inner transitions", hi_cnt, 22);

        // R8: zero settings clamp to one cycle and one bit
        load_cfg(0, 0);
        tick(3);
        clr_stats();
        host_tx = 1'b0; tick(1);
        host_tx = 1'b1; tick(2);
        host_tx = 1'b0; tick(2);
        host_tx = 1'b1; tick(5);
        check_int("R8 clamp window", hi_cnt, 3);
        check_int("R8 clamp releases", fall_cnt, 2);

        // R5: one cycle per bit, 10 bits
        load_cfg(1, 10);
        tick(3);
        clr_stats();
        send_sym(16'h96, 10, 1);
        tick(5);
        check_int("R5 fast window", hi_cnt, 10);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule